// File: doc/BRIEF.md
# Dual-Instruction Dispatch Group Selector

This block sits between a two-entry decode buffer and the issue stage of an in-order front end. Each cycle it looks at the two oldest decoded instructions and picks how many of them leave the buffer: none, the older one alone, or both. It never skips ahead. Each slot says whether it holds an instruction, whether that instruction goes to the branch queue or the general queue, and how many general-purpose rename registers it needs. The block compares these needs against four inputs: the free completion-queue entries, the free general-queue entries, a branch-queue free flag and a branch-ready flag. It also holds the group to a shared budget of two renames per cycle. A load or store with base update uses the whole rename budget on its own.

The slots follow stream rules. A slot's valid bit offers an instruction, and the returned dispatch count works as the per-slot ready. A count of one accepts slot 0 only. A count of two accepts both slots. A count of zero leaves both slots in the buffer, and the buffer must hold their contents. The decision is registered. All outputs change one clock after the inputs they depend on and stay for one cycle. Besides the count, the block drives one enable per slot toward each issue queue, a mask of completion-queue entries to allocate, and the number of rename registers to allocate. The completion queue has 14 entries by default.

Top module: `dispatch_group_sel`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after reset, every output is zero.
- R2: Outputs are registered. A decision depends only on the inputs sampled at the previous rising clock edge, and it does not change when the inputs change between edges.
- R3: Dispatch is in program order. `cq_alloc` is only ever 2'b00, 2'b01 or 2'b11 (bit i is slot i), and `disp_count` equals the number of bits set in it.
- R4: The number of dispatched instructions never exceeds `cq_free`. With `cq_free` = 1 only slot 0 goes, and with 0 nothing goes.
- R5: At most `giq_free` general instructions dispatch in one cycle, and never more than two.
- R6: A branch (`sN_is_br` = 1) dispatches only when `biq_free` and `br_ready` are both 1. At most one branch dispatches per cycle. When both slots hold branches, only slot 0 dispatches.
- R7: The rename field `sN_ren` encodes 0, 1 or 2 renames. The dispatched slots' renames sum to at most 2, and `ren_alloc` equals that sum. An update-form access (2 renames) in slot 0 dispatches alone if slot 1 needs any rename. It pairs with a slot-1 instruction that needs none. Code 3 is reserved, and a slot carrying it does not dispatch.
- R8: Two general instructions that need one rename each dispatch together when two queue entries and two completion entries are free.
- R9: When `s0_valid` is 0, nothing dispatches, even if slot 1 is valid.
- R10: `giq_en[i]` is set exactly when slot i dispatches and is general. `biq_en[i]` is set exactly when slot i dispatches and is a branch. The two never overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_is_br | input | 1 | Slot 0 targets the branch queue (1) or the general queue (0) |
| s0_ren | input | 2 | Slot 0 rename need: 0, 1, 2; 3 reserved |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_is_br | input | 1 | Slot 1 targets the branch queue (1) or the general queue (0) |
| s1_ren | input | 2 | Slot 1 rename need: 0, 1, 2; 3 reserved |
| cq_free | input | 4 | Free completion-queue entries, 0 to 14 |
| giq_free | input | 3 | Free general-queue entries, 0 to 4 |
| biq_free | input | 1 | Branch queue can accept one entry |
| br_ready | input | 1 | Branch-ready check passes this cycle |
| disp_count | output | 2 | Instructions dispatched (ready to the decode buffer) |
| giq_en | output | 2 | Per-slot write enable toward the general queue |
| biq_en | output | 2 | Per-slot write enable toward the branch queue |
| ren_alloc | output | 2 | Rename registers to allocate this cycle |
| cq_alloc | output | 2 | Per-slot completion-queue allocation mask |

## Verification
The main function is tried with several slot pairs. Two one-rename general instructions show that a legal pair goes through in full. An update-form access followed by a rename user, and then by a rename-free instruction, shows that the budget is checked as a sum and not as a per-slot cap. Branch/branch and general/branch pairs, and a branch that is not ready, show that the branch queue takes at most one instruction and that a stalled older slot blocks the younger one. Resource starvation is tried with one and then zero free completion entries, one free general entry, an empty slot 0 and a reserved rename code. These tests show that each limit trims the group from the young end, and that an input change between edges does not reach the outputs early.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned SLOTS = 2;
  localparam int unsigned REN_FIELD_W = 2;
  localparam logic [REN_FIELD_W-1:0] REN_RESERVED = 2'd3;

  typedef struct packed {
    logic                   valid;
    logic                   is_br;
    logic [REN_FIELD_W-1:0] ren;
  } slot_t;

  typedef struct packed {
    logic                   legal;
    logic                   to_br;
    logic                   to_gen;
    logic [REN_FIELD_W-1:0] ren;
  } need_t;
endpackage

// File: rtl/dsp_slot_need.sv
module dsp_slot_need
  import dsp_pkg::*;
(
  input  slot_t slot_i,
  output need_t need_o
);
  always_comb begin
    need_o.legal  = slot_i.valid && (slot_i.ren != REN_RESERVED);
    need_o.to_br  = slot_i.valid && slot_i.is_br;
    need_o.to_gen = slot_i.valid && !slot_i.is_br;
    need_o.ren    = (slot_i.valid && slot_i.ren != REN_RESERVED) ? slot_i.ren : '0;
  end
endmodule

// File: rtl/dsp_group_pick.sv
module dsp_group_pick
  import dsp_pkg::*;
#(
  parameter int unsigned CQ_W       = 4,
  parameter int unsigned GQ_W       = 3,
  parameter int unsigned REN_BUDGET = 2,
  parameter int unsigned REN_W      = 2
) (
  input  need_t              need0_i,
  input  need_t              need1_i,
  input  logic [CQ_W-1:0]    cq_free_i,
  input  logic [GQ_W-1:0]    giq_free_i,
  input  logic               biq_free_i,
  input  logic               br_ready_i,
  output logic [SLOTS-1:0]   take_o,
  output logic [REN_W-1:0]   ren_sum_o
);
  localparam int unsigned SUM_W = REN_FIELD_W + 1;

  logic             br_path_ok;
  logic             q0_ok, q1_ok;
  logic [SUM_W-1:0] ren_pair;
  logic [SUM_W-1:0] ren_taken;
  logic [GQ_W-1:0]  gen_need_pair;

  always_comb begin
    br_path_ok    = biq_free_i && br_ready_i;
    ren_pair      = SUM_W'(need0_i.ren) + SUM_W'(need1_i.ren);
    gen_need_pair = need0_i.to_gen ? GQ_W'(2) : GQ_W'(1);

    q0_ok = need0_i.to_br ? br_path_ok : (giq_free_i >= GQ_W'(1));
    q1_ok = need1_i.to_br ? (br_path_ok && !need0_i.to_br)
                          : (giq_free_i >= gen_need_pair);

    take_o[0] = need0_i.legal && q0_ok && (cq_free_i >= CQ_W'(1))
                && (SUM_W'(need0_i.ren) <= SUM_W'(REN_BUDGET));
    take_o[1] = take_o[0] && need1_i.legal && q1_ok
                && (cq_free_i >= CQ_W'(2))
                && (ren_pair <= SUM_W'(REN_BUDGET));

    ren_taken = (take_o[0] ? SUM_W'(need0_i.ren) : '0)
              + (take_o[1] ? SUM_W'(need1_i.ren) : '0);
    ren_sum_o = REN_W'(ren_taken);
  end
endmodule

// File: rtl/dispatch_group_sel.sv
module dispatch_group_sel
  import dsp_pkg::*;
#(
  parameter int unsigned CQ_DEPTH   = 14,
  parameter int unsigned GIQ_DEPTH  = 4,
  parameter int unsigned REN_BUDGET = 2,
  localparam int unsigned CQ_W  = $clog2(CQ_DEPTH + 1),
  localparam int unsigned GQ_W  = $clog2(GIQ_DEPTH + 1),
  localparam int unsigned REN_W = $clog2(REN_BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic             s0_is_br,
  input  logic [1:0]       s0_ren,
  input  logic             s1_valid,
  input  logic             s1_is_br,
  input  logic [1:0]       s1_ren,
  input  logic [CQ_W-1:0]  cq_free,
  input  logic [GQ_W-1:0]  giq_free,
  input  logic             biq_free,
  input  logic             br_ready,
  output logic [1:0]       disp_count,
  output logic [1:0]       giq_en,
  output logic [1:0]       biq_en,
  output logic [REN_W-1:0] ren_alloc,
  output logic [1:0]       cq_alloc
);
  slot_t              slot [SLOTS];
  need_t              need [SLOTS];
  logic [SLOTS-1:0]   take;
  logic [REN_W-1:0]   ren_sum;
  logic [SLOTS-1:0]   gen_d, br_d;

  assign slot[0] = '{valid: s0_valid, is_br: s0_is_br, ren: s0_ren};
  assign slot[1] = '{valid: s1_valid, is_br: s1_is_br, ren: s1_ren};

  for (genvar g = 0; g < SLOTS; g++) begin : g_need
    dsp_slot_need u_need (
      .slot_i (slot[g]),
      .need_o (need[g])
    );
    assign gen_d[g] = take[g] && need[g].to_gen;
    assign br_d[g]  = take[g] && need[g].to_br;
  end

  dsp_group_pick #(
    .CQ_W       (CQ_W),
    .GQ_W       (GQ_W),
    .REN_BUDGET (REN_BUDGET),
    .REN_W      (REN_W)
  ) u_pick (
    .need0_i    (need[0]),
    .need1_i    (need[1]),
    .cq_free_i  (cq_free),
    .giq_free_i (giq_free),
    .biq_free_i (biq_free),
    .br_ready_i (br_ready),
    .take_o     (take),
    .ren_sum_o  (ren_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_count <= '0;
      giq_en     <= '0;
      biq_en     <= '0;
      ren_alloc  <= '0;
      cq_alloc   <= '0;
    end else begin
      disp_count <= 2'(take[0]) + 2'(take[1]);
      giq_en     <= gen_d;
      biq_en     <= br_d;
      ren_alloc  <= ren_sum;
      cq_alloc   <= take;
    end
  end
endmodule

// File: rtl/dispatch_group_sel_chk.sv
module dispatch_group_sel_chk #(
  parameter int unsigned CQ_W  = 4,
  parameter int unsigned GQ_W  = 3,
  parameter int unsigned REN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s0_valid,
  input logic             s0_is_br,
  input logic [1:0]       s0_ren,
  input logic             s1_valid,
  input logic             s1_is_br,
  input logic [1:0]       s1_ren,
  input logic [CQ_W-1:0]  cq_free,
  input logic [GQ_W-1:0]  giq_free,
  input logic             biq_free,
  input logic             br_ready,
  input logic [1:0]       disp_count,
  input logic [1:0]       giq_en,
  input logic [1:0]       biq_en,
  input logic [REN_W-1:0] ren_alloc,
  input logic [1:0]       cq_alloc
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    cq_alloc != 2'b10);
  a_r3_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    disp_count == 2'($countones(cq_alloc)));
  a_r4_cq_limit: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (CQ_W'(disp_count) <= $past(cq_free)));
  a_r5_giq_limit: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (GQ_W'($countones(giq_en)) <= $past(giq_free)));
  a_r6_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(biq_en) <= 1);
  a_r6_branch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && biq_en != 2'b00) |-> $past(biq_free && br_ready));
  a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
    ren_alloc <= REN_W'(2));
  a_r9_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(s0_valid)) |-> cq_alloc == 2'b00);
  a_r10_route: assert property (@(posedge clk) disable iff (!rst_n)
    ((giq_en & biq_en) == 2'b00) && ((giq_en | biq_en) == cq_alloc));
endmodule

bind dispatch_group_sel dispatch_group_sel_chk #(
  .CQ_W (CQ_W), .GQ_W (GQ_W), .REN_W (REN_W)
) chk_i (.*);

// File: tb/dispatch_group_sel_tb_top.sv
module dispatch_group_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0_valid = 0, s0_is_br = 0, s1_valid = 0, s1_is_br = 0;
  logic [1:0] s0_ren = 0, s1_ren = 0;
  logic [3:0] cq_free = 0;
  logic [2:0] giq_free = 0;
  logic       biq_free = 0, br_ready = 0;
  logic [1:0] disp_count, giq_en, biq_en, ren_alloc, cq_alloc;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dispatch_group_sel dut_i (.*);

  task automatic check(string req, logic [9:0] exp);
    logic [9:0] act;
    act = {disp_count, giq_en, biq_en, ren_alloc, cq_alloc};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got cnt/giq/biq/ren/cq=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic v0, logic b0, logic [1:0] r0,
                       logic v1, logic b1, logic [1:0] r1,
                       logic [3:0] cq, logic [2:0] gq, logic bq, logic rdy);
    @(negedge clk);
    s0_valid = v0; s0_is_br = b0; s0_ren = r0;
    s1_valid = v1; s1_is_br = b1; s1_ren = r1;
    cq_free = cq; giq_free = gq; biq_free = bq; br_ready = rdy;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    drive(1,0,1, 1,0,1, 14,4,1,1);
    check("R1 during reset", 10'b00_00_00_00_00);
    @(negedge clk); rst_n = 1'b1;
    drive(0,0,0, 0,0,0, 14,4,1,1);
    check("R1 after reset", 10'b00_00_00_00_00);
  endtask

  task automatic t_add_mul;
    drive(1,0,1, 1,0,1, 14,4,1,1);
    check("R8 add+mul pair", 10'b10_11_00_10_11);
  endtask

  task automatic t_update;
    drive(1,0,2, 1,0,1, 14,4,1,1);
    check("R7 update then rename user", 10'b01_01_00_10_01);
    drive(1,0,2, 1,0,0, 14,4,1,1);
    check("R7 update then no-rename", 10'b10_11_00_10_11);
    drive(1,0,3, 1,0,0, 14,4,1,1);
    check("R7 reserved code", 10'b00_00_00_00_00);
  endtask

  task automatic t_branches;
    drive(1,1,0, 1,1,0, 14,4,1,1);
    check("R6 two branches", 10'b01_00_01_00_01);
    drive(1,1,0, 1,0,1, 14,4,1,0);
    check("R6 branch not ready blocks R3", 10'b00_00_00_00_00);
    drive(1,1,0, 1,0,1, 14,4,0,1);
    check("R6 branch queue full", 10'b00_00_00_00_00);
    drive(1,0,1, 1,1,0, 14,4,1,1);
    check("R10 general then branch", 10'b10_01_10_01_11);
  endtask

  task automatic t_resources;
    drive(1,0,1, 1,0,1, 1,4,1,1);
    check("R4 one cq entry", 10'b01_01_00_01_01);
    drive(1,0,1, 1,0,1, 0,4,1,1);
    check("R4 no cq entry", 10'b00_00_00_00_00);
    drive(1,0,1, 1,0,1, 14,1,1,1);
    check("R5 one giq entry", 10'b01_01_00_01_01);
    drive(1,1,0, 1,0,1, 14,1,1,1);
    check("R5 branch then general", 10'b10_10_01_01_11);
    drive(0,0,0, 1,0,1, 14,4,1,1);
    check("R9 empty slot 0", 10'b00_00_00_00_00);
  endtask

  task automatic t_latency;
    drive(1,0,1, 1,0,1, 14,4,1,1);
    @(negedge clk);
    s0_valid = 0; cq_free = 0;
    #2;
    check("R2 held between edges", 10'b10_11_00_10_11);
    @(posedge clk); #1;
    check("R2 updates at edge", 10'b00_00_00_00_00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_add_mul();
        t_update();
        t_branches();
        t_resources();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule